// File: doc/BRIEF.md
# Low-Frequency Compare Counter Core

This block is the counting core of a real-time counter that runs from a slow clock. An up-counter of `CNT_W` bits (24 by default) advances once per slow-clock cycle while enabled. Two compare channels each hold a value. An event flag sets when the count steps onto a channel's value, and another flag sets when the count wraps to zero. A pending flag drives the interrupt request only when its enable bit is set.

Control, compare, interrupt-enable and flag-clear values arrive through simple write strobes. They are already synchronized into the slow domain. The wrap point is either the all-ones value or the compare 0 value. A debug-run control decides whether the count freezes while a debugger halts the system. Clearing the enable bit holds the count at zero, so clearing the bit and then setting it again restarts counting from zero.

Top module: `lfc_counter_core`

## Requirements
- R1: The count is `CNT_W` bits wide (default 24) and advances by one on each clock edge while enabled. With the top-select bit clear, it goes from all-ones to zero.
- R2: With the top-select bit set, the edge after the count equals the compare 0 value returns the count to zero. The edge after the count reaches all-ones also returns it to zero.
- R3: A compare write keeps only the low `CNT_W` bits of `cmp_wdata`. The stored value appears on `cmp_rdata` when `cmp_ridx` selects that channel (0 or 1).
- R4: While the enable bit is clear, the count is forced to zero. Setting the bit again starts counting from zero, and the first increment comes one edge after the control write loads.
- R5: While `dbg_halt` is high and the debug-run bit is clear, the count holds. With debug-run set, the count keeps advancing.
- R6: After reset, the control register, both compare values, the interrupt enables, the flags and the count are all zero.
- R7: Flag bit 0 (overflow) sets on the edge where the count wraps to zero. Bit 1 sets on the edge where the count steps onto the compare 0 value, and bit 2 does the same for compare 1. A flag set wins over a clear in the same cycle.
- R8: Flags stay set until `clr_wr` is asserted with the matching bit in `clr_mask`.
- R9: `irq` is high exactly when some flag bit and the matching `ien` bit are both set. `ien_wdata` uses the same bit positions as the flags.
- R10: A compare write with index 2 or 3 changes nothing, and a read at index 2 or 3 returns zero.
- R11: `ctrl_wdata` bit 0 is enable, bit 1 is debug-run and bit 2 is top-select. Every register write takes effect at the clock edge on which its strobe is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow counter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbg_halt | input | 1 | Debugger has halted the system |
| ctrl_wr | input | 1 | Load control bits |
| ctrl_wdata | input | 3 | {top-select, debug-run, enable} |
| cmp_wr | input | 1 | Load a compare channel |
| cmp_widx | input | 2 | Compare channel written |
| cmp_wdata | input | 32 | Compare write value; bits above CNT_W-1 are dropped |
| cmp_ridx | input | 2 | Compare channel read |
| cmp_rdata | output | CNT_W | Selected compare value, or zero for an invalid index |
| ien_wr | input | 1 | Load interrupt enables |
| ien_wdata | input | 3 | Interrupt enables {cmp1, cmp0, overflow} |
| clr_wr | input | 1 | Clear flags |
| clr_mask | input | 3 | Flags to clear |
| count | output | CNT_W | Current count |
| flags | output | 3 | Pending flags {cmp1, cmp0, overflow} |
| irq | output | 1 | Interrupt request |

## Verification
Most faulty internal states in this block show up at the ports within one edge. A wrong increment or a missed wrap puts the wrong value on `count` at the next edge. A wrong compare store or index decode changes `cmp_rdata` as soon as the read index selects it. A lost event, or a clear that beats a set, leaves `flags` wrong from the next edge onward, and a bad mask shows as a wrong `irq` in the same cycle. Faults in the top-select path and the overflow flag stay hidden until the count reaches its wrap point, so the checks run the count all the way around both wrap points.

// File: rtl/lfc_pkg.sv
package lfc_pkg;
  // control word layout
  typedef struct packed {
    logic top_sel;   // bit 2: compare 0 is the wrap point
    logic dbg_run;   // bit 1: keep counting under debug halt
    logic enable;    // bit 0: counter runs
  } lfc_ctrl_t;

  localparam int FLG_OVF = 0;  // flag index of the wrap event
  localparam int FLG_CMP = 1;  // flag index of compare channel 0
endpackage

// File: rtl/lfc_regs.sv
module lfc_regs #(
  parameter int CNT_W = 24,
  parameter int BUS_W = 32,
  parameter int CMP_N = 2,
  parameter int IDX_W = 2,
  parameter int FLG_W = CMP_N + 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ctrl_wr,
  input  lfc_pkg::lfc_ctrl_t           ctrl_wdata,
  input  logic                         cmp_wr,
  input  logic [IDX_W-1:0]             cmp_widx,
  input  logic [BUS_W-1:0]             cmp_wdata,
  input  logic [IDX_W-1:0]             cmp_ridx,
  input  logic                         ien_wr,
  input  logic [FLG_W-1:0]             ien_wdata,
  output lfc_pkg::lfc_ctrl_t           ctrl_q,
  output logic [CMP_N-1:0][CNT_W-1:0]  cmp_q,
  output logic [FLG_W-1:0]             ien_q,
  output logic [CNT_W-1:0]             cmp_rdata
);
  localparam logic [BUS_W-1:0] KEEP = BUS_W'((64'd1 << CNT_W) - 64'd1);

  function automatic logic [CNT_W-1:0] fit_value(input logic [BUS_W-1:0] raw);
    return CNT_W'(raw & KEEP);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ien_q  <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_wdata;
      if (ien_wr)  ien_q  <= ien_wdata;
    end
  end

  for (genvar ch = 0; ch < CMP_N; ch++) begin : g_cmp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cmp_q[ch] <= '0;
      else if (cmp_wr && cmp_widx == IDX_W'(ch))
        cmp_q[ch] <= fit_value(cmp_wdata);
    end
  end

  always_comb begin
    cmp_rdata = '0;
    for (int ch = 0; ch < CMP_N; ch++)
      if (cmp_ridx == IDX_W'(ch)) cmp_rdata = cmp_q[ch];
  end

  assert_cmp0_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_wr && cmp_widx == '0) |=> (cmp_q[0] == $past(cmp_wdata[CNT_W-1:0])));

  assert_bad_index_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_wr && cmp_widx >= IDX_W'(CMP_N)) |=> $stable(cmp_q));
endmodule

// File: rtl/lfc_count.sv
module lfc_count #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             dbg_run,
  input  logic             top_sel,
  input  logic             dbg_halt,
  input  logic [CNT_W-1:0] top_cmp,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] count_nxt,
  output logic             step,
  output logic             wrap_evt
);
  localparam logic [CNT_W-1:0] ALL1 = '1;

  function automatic logic [CNT_W-1:0] wrap_point(input logic sel,
                                                  input logic [CNT_W-1:0] c0);
    return sel ? c0 : ALL1;
  endfunction

  function automatic logic at_limit(input logic [CNT_W-1:0] cur,
                                    input logic [CNT_W-1:0] lim);
    return (cur == lim) || (cur == ALL1);
  endfunction

  logic [CNT_W-1:0] limit;

  always_comb begin
    limit     = wrap_point(top_sel, top_cmp);
    step      = enable && (!dbg_halt || dbg_run);
    wrap_evt  = step && at_limit(count, limit);
    count_nxt = at_limit(count, limit) ? '0 : count + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (!enable) count <= '0;
    else if (step)    count <= count_nxt;
  end

  assert_off_is_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (count == '0));

  assert_halt_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && dbg_halt && !dbg_run) |=> $stable(count));

  assert_top_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && top_sel && count == top_cmp) |=> (count == '0));

  assert_wrap_lands_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (count == '0));
endmodule

// File: rtl/lfc_flags.sv
module lfc_flags #(
  parameter int FLG_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FLG_W-1:0] set_evt,
  input  logic             clr_wr,
  input  logic [FLG_W-1:0] clr_mask,
  input  logic [FLG_W-1:0] ien,
  output logic [FLG_W-1:0] flags,
  output logic             irq
);
  logic [FLG_W-1:0] clr_eff;

  always_comb begin
    clr_eff = clr_wr ? clr_mask : '0;
    irq     = |(flags & ien);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_eff) | set_evt;
  end

  assert_set_sticks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt != '0) |=> ((flags & $past(set_evt)) == $past(set_evt)));

  assert_clear_works_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((flags & $past(clr_mask & ~set_evt)) == '0));
endmodule

// File: rtl/lfc_counter_core.sv
module lfc_counter_core #(
  parameter int CNT_W = 24,
  parameter int BUS_W = 32,
  parameter int CMP_N = 2,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dbg_halt,
  input  logic             ctrl_wr,
  input  logic [2:0]       ctrl_wdata,
  input  logic             cmp_wr,
  input  logic [IDX_W-1:0] cmp_widx,
  input  logic [BUS_W-1:0] cmp_wdata,
  input  logic [IDX_W-1:0] cmp_ridx,
  output logic [CNT_W-1:0] cmp_rdata,
  input  logic             ien_wr,
  input  logic [CMP_N:0]   ien_wdata,
  input  logic             clr_wr,
  input  logic [CMP_N:0]   clr_mask,
  output logic [CNT_W-1:0] count,
  output logic [CMP_N:0]   flags,
  output logic             irq
);
  localparam int FLG_W = CMP_N + 1;

  lfc_pkg::lfc_ctrl_t          ctrl_q;
  logic [CMP_N-1:0][CNT_W-1:0] cmp_q;
  logic [FLG_W-1:0]            ien_q;
  logic [CNT_W-1:0]            count_nxt;
  logic                        step;
  logic                        wrap_evt;
  logic [FLG_W-1:0]            set_evt;

  lfc_regs #(.CNT_W(CNT_W), .BUS_W(BUS_W), .CMP_N(CMP_N), .IDX_W(IDX_W),
             .FLG_W(FLG_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (ctrl_wr),
    .ctrl_wdata (lfc_pkg::lfc_ctrl_t'(ctrl_wdata)),
    .cmp_wr     (cmp_wr),
    .cmp_widx   (cmp_widx),
    .cmp_wdata  (cmp_wdata),
    .cmp_ridx   (cmp_ridx),
    .ien_wr     (ien_wr),
    .ien_wdata  (ien_wdata),
    .ctrl_q     (ctrl_q),
    .cmp_q      (cmp_q),
    .ien_q      (ien_q),
    .cmp_rdata  (cmp_rdata)
  );

  lfc_count #(.CNT_W(CNT_W)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (ctrl_q.enable),
    .dbg_run   (ctrl_q.dbg_run),
    .top_sel   (ctrl_q.top_sel),
    .dbg_halt  (dbg_halt),
    .top_cmp   (cmp_q[0]),
    .count     (count),
    .count_nxt (count_nxt),
    .step      (step),
    .wrap_evt  (wrap_evt)
  );

  // per-event wires: overflow at FLG_OVF, channel ch at FLG_CMP+ch
  assign set_evt[lfc_pkg::FLG_OVF] = wrap_evt;
  for (genvar ch = 0; ch < CMP_N; ch++) begin : g_match
    assign set_evt[lfc_pkg::FLG_CMP + ch] = step && (count_nxt == cmp_q[ch]);
  end

  lfc_flags #(.FLG_W(FLG_W)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_evt  (set_evt),
    .clr_wr   (clr_wr),
    .clr_mask (clr_mask),
    .ien      (ien_q),
    .flags    (flags),
    .irq      (irq)
  );

  assert_match_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.enable && step && count_nxt == cmp_q[0]) |=> (flags[lfc_pkg::FLG_CMP] && count == $past(cmp_q[0])));
endmodule

// File: tb/lfc_counter_core_bench.sv
module lfc_counter_core_bench;
  localparam int W    = 8;
  localparam int MAXV = (1 << W) - 1;

  logic         clk = 0;
  logic         rst_n = 0;
  logic         dbg_halt = 0;
  logic         ctrl_wr = 0;
  logic [2:0]   ctrl_wdata = '0;
  logic         cmp_wr = 0;
  logic [1:0]   cmp_widx = '0;
  logic [31:0]  cmp_wdata = '0;
  logic [1:0]   cmp_ridx = '0;
  logic [W-1:0] cmp_rdata;
  logic         ien_wr = 0;
  logic [2:0]   ien_wdata = '0;
  logic         clr_wr = 0;
  logic [2:0]   clr_mask = '0;
  logic [W-1:0] count;
  logic [2:0]   flags;
  logic         irq;

  int errors = 0;
  int checks = 0;
  string cur_req = "R6";

  // reference state
  bit m_en, m_dbg, m_top;
  int m_c[2];
  int m_cnt;
  bit [2:0] m_ien, m_flg;

  int q_cnt[$];
  int q_flg[$];
  int q_irq[$];
  string q_req[$];

  always #2.5 clk = ~clk;

  lfc_counter_core #(.CNT_W(W)) u_lfc_counter_core (
    .clk(clk), .rst_n(rst_n), .dbg_halt(dbg_halt),
    .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .cmp_wr(cmp_wr), .cmp_widx(cmp_widx), .cmp_wdata(cmp_wdata),
    .cmp_ridx(cmp_ridx), .cmp_rdata(cmp_rdata),
    .ien_wr(ien_wr), .ien_wdata(ien_wdata),
    .clr_wr(clr_wr), .clr_mask(clr_mask),
    .count(count), .flags(flags), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference update for one edge, computed from the requirements
  task automatic model_edge();
    bit [2:0] ev = '0;
    int lim;
    int nxt;
    if (!m_en) m_cnt = 0;
    else if (!dbg_halt || m_dbg) begin
      lim = m_top ? m_c[0] : MAXV;
      if (m_cnt == lim || m_cnt == MAXV) begin nxt = 0; ev[0] = 1; end
      else nxt = m_cnt + 1;
      if (nxt == m_c[0]) ev[1] = 1;
      if (nxt == m_c[1]) ev[2] = 1;
      m_cnt = nxt;
    end
    if (clr_wr) m_flg = m_flg & ~clr_mask;
    m_flg = m_flg | ev;
    if (ctrl_wr) {m_top, m_dbg, m_en} = ctrl_wdata;
    if (cmp_wr && cmp_widx < 2) m_c[cmp_widx] = int'(cmp_wdata) & MAXV;
    if (ien_wr) m_ien = ien_wdata;
    q_cnt.push_back(m_cnt);
    q_flg.push_back(int'(m_flg));
    q_irq.push_back(int'((m_flg & m_ien) != 0));
    q_req.push_back(cur_req);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    model_edge();
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr_ctrl(input bit [2:0] v);
    ctrl_wr = 1; ctrl_wdata = v; step(); ctrl_wr = 0;
  endtask

  task automatic wr_cmp(input bit [1:0] idx, input bit [31:0] v);
    cmp_wr = 1; cmp_widx = idx; cmp_wdata = v; step(); cmp_wr = 0;
  endtask

  task automatic wr_ien(input bit [2:0] v);
    ien_wr = 1; ien_wdata = v; step(); ien_wr = 0;
  endtask

  task automatic wr_clr(input bit [2:0] v);
    clr_wr = 1; clr_mask = v; step(); clr_wr = 0;
  endtask

  // monitor: compare one expected item per edge
  always @(negedge clk) begin
    if (q_cnt.size() > 0) begin
      string r;
      r = q_req.pop_front();
      chk({r, " count"}, int'(count), q_cnt.pop_front());
      chk({r, " flags"}, int'(flags), q_flg.pop_front());
      chk({r, " irq"},   int'(irq),   q_irq.pop_front());
    end
  end

  bit done = 0;

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_c[0] = 0; m_c[1] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R6 reset state
    chk("R6 count", int'(count), 0);
    chk("R6 flags", int'(flags), 0);
    chk("R6 irq", int'(irq), 0);
    cmp_ridx = 0; #0.5;
    chk("R6 cmp0", int'(cmp_rdata), 0);

    cur_req = "R3";
    wr_cmp(0, 32'hFFFF_FF05);
    cmp_ridx = 0; #0.5;
    chk("R3 masked store", int'(cmp_rdata), 5);
    wr_cmp(1, 32'h0000_0003);
    cmp_ridx = 1; #0.5;
    chk("R3 cmp1 readback", int'(cmp_rdata), 3);
    cur_req = "R10";
    wr_cmp(2, 32'd77);
    cmp_ridx = 2; #0.5;
    chk("R10 bad index read", int'(cmp_rdata), 0);
    cmp_ridx = 0; #0.5;
    chk("R10 bad index write ignored", int'(cmp_rdata), 5);

    cur_req = "R1";
    wr_ien(3'b110);
    wr_ctrl(3'b001);
    chk("R11 enable load edge", int'(count), 0);
    steps(10);
    chk("R1 count advanced", int'(count), 10);
    chk("R7 compare flags", int'(flags), 3'b110);
    chk("R9 irq enabled", int'(irq), 1);

    cur_req = "R8";
    wr_clr(3'b111);
    chk("R8 flags cleared", int'(flags), 0);

    cur_req = "R1";
    steps(244);
    chk("R1 at all-ones", int'(count), MAXV);
    step();
    chk("R1 full wrap", int'(count), 0);
    chk("R7 overflow flag", int'(flags), 3'b001);
    chk("R9 masked overflow", int'(irq), 0);

    cur_req = "R2";
    wr_ctrl(3'b101);
    steps(4);
    chk("R2 reached top", int'(count), 5);
    step();
    chk("R2 top wrap", int'(count), 0);

    cur_req = "R4";
    steps(3);
    wr_ctrl(3'b100);
    step();
    chk("R4 disabled zero", int'(count), 0);
    wr_ctrl(3'b101);
    step();
    chk("R4 restart from zero", int'(count), 1);

    cur_req = "R5";
    dbg_halt = 1;
    steps(4);
    chk("R5 halted hold", int'(count), 1);
    wr_ctrl(3'b111);
    step();
    chk("R5 debug-run counts", int'(count), 2);
    dbg_halt = 0;

    cur_req = "R7";
    wr_clr(3'b100);
    chk("R7 set beats clear", int'(flags[2]), 1);

    cur_req = "R9";
    wr_ien(3'b000);
    chk("R9 flags pending", int'(flags != 0), 1);
    chk("R9 irq masked", int'(irq), 0);

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule